// File: doc/BRIEF.md
# Token-Balancing Compute Unit Partitioner

This block decides which kernel owns each compute unit of a shared execution engine. Each active kernel carries a signed token budget, which is its fair share of units minus the units it currently holds. When an event arrives, the partitioner makes repeated passes over the unit status table and the kernel token counters. In each pass it finds the richest kernel that still has work to issue, the poorest active kernel and a free unit. It then issues one table write and the matching token updates. Passes continue until no useful move remains.

The status table and the token counters sit outside the block, next to the logic that issues work and drains preempted units. The partitioner reads them as flat vectors and drives write strobes back. Each pass walks every unit index one per clock with a single counter, then spends one decision cycle. The cost of a pass is fixed and does not depend on the data. A free unit is handed to the richest kernel even when that kernel's budget is already exhausted, so the count can go negative. When no unit is free, a running unit of the poorest kernel is marked reserved for the richest one, and the external logic then drains it.

Top module: `token_partitioner`

## Requirements
- R1: During reset and in the first cycle after it, `busy_o` is low and no unit write, token increment or token decrement strobe is asserted.
- R2: A one-cycle pulse on `ev_insert_i` or on `ev_idle_i` while the block is idle raises `busy_o` in the next cycle and starts a run. Without such a pulse the block stays idle and issues no writes, whatever the tables hold.
- R3: A pass reads unit/kernel index 0 to NUM_UNITS-1 in one cycle each and then decides in one extra cycle. The decision cycle is the only cycle that may carry writes, and it carries at most one unit write. A run that makes `a` moves stays busy for exactly (a+1)*(NUM_UNITS+1) cycles, and its first write appears in busy cycle NUM_UNITS+1.
- R4: The richest kernel is the active kernel with its work flag set and the largest token count. The poorest kernel is the active kernel with the smallest token count. On a tie, the lower kernel index wins in both cases.
- R5: If a richest kernel exists and some unit has state code 0 (free), the lowest-numbered free unit is written with state code 1 (running) and the richest kernel as owner, and that kernel's token count is decremented by one. This happens even if the count becomes negative.
- R6: If no unit is free, the richest count exceeds the poorest count plus one, and the poorest kernel owns a unit in state 1, then the lowest-numbered such unit is written with state code 2 (reserved) and the richest kernel as its next owner. In the same cycle the poorest kernel is incremented and the richest kernel is decremented.
- R7: If neither R5 nor R6 applies, the decision cycle issues no write and the run ends. This covers the case with no richest kernel, counts within one of each other, and a poorest kernel that owns no running unit.
- R8: An event that arrives while a run is busy is remembered. Another full run starts in the cycle right after the current run ends, with no idle cycle between the two runs.
- R9: Token counts are TOK_W-bit two's complement values, TOK_W-bit field k of `kern_tok_i` for kernel k. Unit u uses bits [2u+1:2u] of `unit_state_i` and KW-bit field u of `unit_owner_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_insert_i | input | 1 | Pulse: a kernel joined the active set |
| ev_idle_i | input | 1 | Pulse: a unit became free |
| unit_state_i | input | 2*NUM_UNITS | Per-unit state code (0 free, 1 running, 2 reserved) |
| unit_owner_i | input | KW*NUM_UNITS | Per-unit owning kernel index |
| kern_active_i | input | NUM_KERN | Kernel slot holds an active kernel |
| kern_work_i | input | NUM_KERN | Kernel still has blocks to issue |
| kern_tok_i | input | TOK_W*NUM_KERN | Signed token count per kernel |
| busy_o | output | 1 | A run is in progress |
| unit_we_o | output | 1 | Unit table write strobe |
| unit_widx_o | output | UW | Unit index written |
| unit_wstate_o | output | 2 | New state code for that unit |
| unit_wkern_o | output | KW | Owner (state 1) or next owner (state 2) |
| tok_inc_o | output | 1 | Increment one token counter |
| tok_inc_idx_o | output | KW | Kernel incremented |
| tok_dec_o | output | 1 | Decrement one token counter |
| tok_dec_idx_o | output | KW | Kernel decremented |

## Verification
The preemption path is the hardest one to reach from the ports. It needs a table with no free unit, a gap of at least two tokens between the richest and poorest kernels, and a poorest kernel that still holds a running unit. The bench builds this directly with every unit running for one kernel while a newcomer holds tokens. Random trials draw mostly occupied tables to reach mixed cases. A second event is injected at a chosen busy cycle to exercise the remembered rerun, including the case where the event lands on the final decision cycle.

// File: rtl/tokpart_pkg.sv
package tokpart_pkg;
    typedef enum logic [1:0] {
        U_FREE = 2'd0,
        U_RUN  = 2'd1,
        U_RSV  = 2'd2
    } unit_state_e;

    typedef enum logic [1:0] {
        P_WAIT   = 2'd0,
        P_SCAN   = 2'd1,
        P_DECIDE = 2'd2
    } phase_e;
endpackage

// File: rtl/tokpart_unit_probe.sv
module tokpart_unit_probe
    import tokpart_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int NUM_KERN  = 4,
    parameter int UW        = 3,
    parameter int KW        = 2
) (
    input  logic                          en,
    input  logic [UW-1:0]                 idx,
    input  logic [2*NUM_UNITS-1:0]        unit_state_i,
    input  logic [KW*NUM_UNITS-1:0]       unit_owner_i,
    input  logic                          has_free_q,
    input  logic [UW-1:0]                 free_u_q,
    input  logic [NUM_KERN-1:0]           vic_v_q,
    input  logic [NUM_KERN-1:0][UW-1:0]   vic_u_q,
    output logic                          has_free_d,
    output logic [UW-1:0]                 free_u_d,
    output logic [NUM_KERN-1:0]           vic_v_d,
    output logic [NUM_KERN-1:0][UW-1:0]   vic_u_d
);
    logic [1:0]    st_arr  [NUM_UNITS];
    logic [KW-1:0] own_arr [NUM_UNITS];
    logic [1:0]    st;
    logic [KW-1:0] own;

    always_comb begin
        for (int u = 0; u < NUM_UNITS; u++) begin
            st_arr[u]  = unit_state_i[2*u +: 2];
            own_arr[u] = unit_owner_i[KW*u +: KW];
        end
    end

    assign st  = st_arr[idx];
    assign own = own_arr[idx];

    // First free unit, and for every kernel its first running unit
    always_comb begin
        has_free_d = has_free_q;
        free_u_d   = free_u_q;
        vic_v_d    = vic_v_q;
        vic_u_d    = vic_u_q;
        if (en) begin
            if (st == U_FREE && !has_free_q) begin
                has_free_d = 1'b1;
                free_u_d   = idx;
            end
            if (st == U_RUN && !vic_v_q[own]) begin
                vic_v_d[own] = 1'b1;
                vic_u_d[own] = idx;
            end
        end
    end
endmodule

// File: rtl/tokpart_kern_probe.sv
module tokpart_kern_probe #(
    parameter int NUM_KERN = 4,
    parameter int TOK_W    = 5,
    parameter int KW       = 2
) (
    input  logic                        en,
    input  logic [KW-1:0]               kidx,
    input  logic [NUM_KERN-1:0]         kern_active_i,
    input  logic [NUM_KERN-1:0]         kern_work_i,
    input  logic [TOK_W*NUM_KERN-1:0]   kern_tok_i,
    input  logic                        has_max_q,
    input  logic [KW-1:0]               max_k_q,
    input  logic signed [TOK_W-1:0]     max_t_q,
    input  logic                        has_min_q,
    input  logic [KW-1:0]               min_k_q,
    input  logic signed [TOK_W-1:0]     min_t_q,
    output logic                        has_max_d,
    output logic [KW-1:0]               max_k_d,
    output logic signed [TOK_W-1:0]     max_t_d,
    output logic                        has_min_d,
    output logic [KW-1:0]               min_k_d,
    output logic signed [TOK_W-1:0]     min_t_d
);
    logic signed [TOK_W-1:0] tok_arr [NUM_KERN];
    logic signed [TOK_W-1:0] t;
    logic                    act, work;

    always_comb begin
        for (int k = 0; k < NUM_KERN; k++) begin
            tok_arr[k] = kern_tok_i[TOK_W*k +: TOK_W];
        end
    end

    assign t    = tok_arr[kidx];
    assign act  = kern_active_i[kidx];
    assign work = kern_work_i[kidx];

    // Strict comparisons keep the lower index on ties
    always_comb begin
        has_max_d = has_max_q;
        max_k_d   = max_k_q;
        max_t_d   = max_t_q;
        has_min_d = has_min_q;
        min_k_d   = min_k_q;
        min_t_d   = min_t_q;
        if (en && act && work && (!has_max_q || t > max_t_q)) begin
            has_max_d = 1'b1;
            max_k_d   = kidx;
            max_t_d   = t;
        end
        if (en && act && (!has_min_q || t < min_t_q)) begin
            has_min_d = 1'b1;
            min_k_d   = kidx;
            min_t_d   = t;
        end
    end
endmodule

// File: rtl/tokpart_decide.sv
module tokpart_decide
    import tokpart_pkg::*;
#(
    parameter int NUM_KERN = 4,
    parameter int TOK_W    = 5,
    parameter int UW       = 3,
    parameter int KW       = 2
) (
    input  logic                         en,
    input  logic                         has_max,
    input  logic [KW-1:0]                max_k,
    input  logic signed [TOK_W-1:0]      max_t,
    input  logic                         has_min,
    input  logic [KW-1:0]                min_k,
    input  logic signed [TOK_W-1:0]      min_t,
    input  logic                         has_free,
    input  logic [UW-1:0]                free_u,
    input  logic [NUM_KERN-1:0]          vic_v,
    input  logic [NUM_KERN-1:0][UW-1:0]  vic_u,
    output logic                         move_o,
    output logic                         unit_we_o,
    output logic [UW-1:0]                unit_widx_o,
    output logic [1:0]                   unit_wstate_o,
    output logic [KW-1:0]                unit_wkern_o,
    output logic                         tok_inc_o,
    output logic [KW-1:0]                tok_inc_idx_o,
    output logic                         tok_dec_o,
    output logic [KW-1:0]                tok_dec_idx_o
);
    logic signed [TOK_W:0] max_w, lim_w;
    logic can_fill, can_take;

    assign max_w    = {max_t[TOK_W-1], max_t};
    assign lim_w    = {min_t[TOK_W-1], min_t} + (TOK_W+1)'(1);
    assign can_fill = has_max && has_free;
    assign can_take = has_max && has_min && (max_w > lim_w) && vic_v[min_k];

    always_comb begin
        move_o        = 1'b0;
        unit_we_o     = 1'b0;
        unit_widx_o   = '0;
        unit_wstate_o = U_FREE;
        unit_wkern_o  = max_k;
        tok_inc_o     = 1'b0;
        tok_inc_idx_o = min_k;
        tok_dec_o     = 1'b0;
        tok_dec_idx_o = max_k;
        if (en && can_fill) begin
            move_o        = 1'b1;
            unit_we_o     = 1'b1;
            unit_widx_o   = free_u;
            unit_wstate_o = U_RUN;
            tok_dec_o     = 1'b1;
        end else if (en && can_take) begin
            move_o        = 1'b1;
            unit_we_o     = 1'b1;
            unit_widx_o   = vic_u[min_k];
            unit_wstate_o = U_RSV;
            tok_inc_o     = 1'b1;
            tok_dec_o     = 1'b1;
        end
    end
endmodule

// File: rtl/token_partitioner.sv
module token_partitioner
    import tokpart_pkg::*;
#(
    parameter int NUM_UNITS = 8,
    parameter int NUM_KERN  = 4,
    parameter int TOK_W     = $clog2(NUM_UNITS) + 2,
    localparam int UW       = $clog2(NUM_UNITS),
    localparam int KW       = $clog2(NUM_KERN)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        ev_insert_i,
    input  logic                        ev_idle_i,
    input  logic [2*NUM_UNITS-1:0]      unit_state_i,
    input  logic [KW*NUM_UNITS-1:0]     unit_owner_i,
    input  logic [NUM_KERN-1:0]         kern_active_i,
    input  logic [NUM_KERN-1:0]         kern_work_i,
    input  logic [TOK_W*NUM_KERN-1:0]   kern_tok_i,
    output logic                        busy_o,
    output logic                        unit_we_o,
    output logic [UW-1:0]               unit_widx_o,
    output logic [1:0]                  unit_wstate_o,
    output logic [KW-1:0]               unit_wkern_o,
    output logic                        tok_inc_o,
    output logic [KW-1:0]               tok_inc_idx_o,
    output logic                        tok_dec_o,
    output logic [KW-1:0]               tok_dec_idx_o
);
    localparam logic [UW:0]   KLIM = (UW+1)'(NUM_KERN);
    localparam logic [UW-1:0] LAST = UW'(NUM_UNITS - 1);

    typedef struct packed {
        phase_e                        phase;
        logic [UW-1:0]                 idx;
        logic                          pend;
        logic                          has_free;
        logic [UW-1:0]                 free_u;
        logic [NUM_KERN-1:0]           vic_v;
        logic [NUM_KERN-1:0][UW-1:0]   vic_u;
        logic                          has_max;
        logic [KW-1:0]                 max_k;
        logic signed [TOK_W-1:0]       max_t;
        logic                          has_min;
        logic [KW-1:0]                 min_k;
        logic signed [TOK_W-1:0]       min_t;
    } state_t;

    state_t s_q, s_d;

    function automatic state_t clear_acc(state_t s);
        state_t r = s;
        r.idx      = '0;
        r.has_free = 1'b0;
        r.vic_v    = '0;
        r.has_max  = 1'b0;
        r.has_min  = 1'b0;
        return r;
    endfunction

    logic scan_en, kern_en, move;
    logic up_has_free;
    logic [UW-1:0] up_free_u;
    logic [NUM_KERN-1:0] up_vic_v;
    logic [NUM_KERN-1:0][UW-1:0] up_vic_u;
    logic kp_has_max, kp_has_min;
    logic [KW-1:0] kp_max_k, kp_min_k;
    logic signed [TOK_W-1:0] kp_max_t, kp_min_t;

    assign scan_en = (s_q.phase == P_SCAN);
    assign kern_en = scan_en && ({1'b0, s_q.idx} < KLIM);

    tokpart_unit_probe #(
        .NUM_UNITS(NUM_UNITS), .NUM_KERN(NUM_KERN), .UW(UW), .KW(KW)
    ) u_unit (
        .en(scan_en), .idx(s_q.idx),
        .unit_state_i(unit_state_i), .unit_owner_i(unit_owner_i),
        .has_free_q(s_q.has_free), .free_u_q(s_q.free_u),
        .vic_v_q(s_q.vic_v), .vic_u_q(s_q.vic_u),
        .has_free_d(up_has_free), .free_u_d(up_free_u),
        .vic_v_d(up_vic_v), .vic_u_d(up_vic_u)
    );

    tokpart_kern_probe #(
        .NUM_KERN(NUM_KERN), .TOK_W(TOK_W), .KW(KW)
    ) u_kern (
        .en(kern_en), .kidx(s_q.idx[KW-1:0]),
        .kern_active_i(kern_active_i), .kern_work_i(kern_work_i),
        .kern_tok_i(kern_tok_i),
        .has_max_q(s_q.has_max), .max_k_q(s_q.max_k), .max_t_q(s_q.max_t),
        .has_min_q(s_q.has_min), .min_k_q(s_q.min_k), .min_t_q(s_q.min_t),
        .has_max_d(kp_has_max), .max_k_d(kp_max_k), .max_t_d(kp_max_t),
        .has_min_d(kp_has_min), .min_k_d(kp_min_k), .min_t_d(kp_min_t)
    );

    tokpart_decide #(
        .NUM_KERN(NUM_KERN), .TOK_W(TOK_W), .UW(UW), .KW(KW)
    ) u_decide (
        .en(s_q.phase == P_DECIDE),
        .has_max(s_q.has_max), .max_k(s_q.max_k), .max_t(s_q.max_t),
        .has_min(s_q.has_min), .min_k(s_q.min_k), .min_t(s_q.min_t),
        .has_free(s_q.has_free), .free_u(s_q.free_u),
        .vic_v(s_q.vic_v), .vic_u(s_q.vic_u),
        .move_o(move),
        .unit_we_o(unit_we_o), .unit_widx_o(unit_widx_o),
        .unit_wstate_o(unit_wstate_o), .unit_wkern_o(unit_wkern_o),
        .tok_inc_o(tok_inc_o), .tok_inc_idx_o(tok_inc_idx_o),
        .tok_dec_o(tok_dec_o), .tok_dec_idx_o(tok_dec_idx_o)
    );

    always_comb begin
        logic ev, pend_now;
        ev       = ev_insert_i | ev_idle_i;
        pend_now = s_q.pend | ev;
        s_d      = s_q;
        unique case (s_q.phase)
            P_WAIT: begin
                if (ev) begin
                    s_d       = clear_acc(s_q);
                    s_d.phase = P_SCAN;
                    s_d.pend  = 1'b0;
                end
            end
            P_SCAN: begin
                s_d.pend     = pend_now;
                s_d.has_free = up_has_free;
                s_d.free_u   = up_free_u;
                s_d.vic_v    = up_vic_v;
                s_d.vic_u    = up_vic_u;
                s_d.has_max  = kp_has_max;
                s_d.max_k    = kp_max_k;
                s_d.max_t    = kp_max_t;
                s_d.has_min  = kp_has_min;
                s_d.min_k    = kp_min_k;
                s_d.min_t    = kp_min_t;
                if (s_q.idx == LAST) s_d.phase = P_DECIDE;
                else                 s_d.idx   = s_q.idx + 1'b1;
            end
            P_DECIDE: begin
                s_d = clear_acc(s_q);
                if (move) begin
                    s_d.phase = P_SCAN;
                    s_d.pend  = pend_now;
                end else if (pend_now) begin
                    s_d.phase = P_SCAN;
                    s_d.pend  = 1'b0;
                end else begin
                    s_d.phase = P_WAIT;
                    s_d.pend  = 1'b0;
                end
            end
            default: s_d.phase = P_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy_o = (s_q.phase != P_WAIT);
endmodule

// File: rtl/tokpart_chk.sv
module tokpart_chk #(
    parameter int NUM_UNITS = 8,
    parameter int NUM_KERN  = 4,
    parameter int TOK_W     = $clog2(NUM_UNITS) + 2,
    localparam int UW       = $clog2(NUM_UNITS),
    localparam int KW       = $clog2(NUM_KERN)
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        ev_insert_i,
    input logic                        ev_idle_i,
    input logic [2*NUM_UNITS-1:0]      unit_state_i,
    input logic [KW*NUM_UNITS-1:0]     unit_owner_i,
    input logic [NUM_KERN-1:0]         kern_active_i,
    input logic [NUM_KERN-1:0]         kern_work_i,
    input logic [TOK_W*NUM_KERN-1:0]   kern_tok_i,
    input logic                        busy_o,
    input logic                        unit_we_o,
    input logic [UW-1:0]               unit_widx_o,
    input logic [1:0]                  unit_wstate_o,
    input logic [KW-1:0]               unit_wkern_o,
    input logic                        tok_inc_o,
    input logic [KW-1:0]               tok_inc_idx_o,
    input logic                        tok_dec_o,
    input logic [KW-1:0]               tok_dec_idx_o
);
    AST_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we_o || tok_inc_o || tok_dec_o) |-> busy_o); // R3
    AST_PASS_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        unit_we_o |=> !unit_we_o); // R3
    AST_START_BY_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(ev_insert_i || ev_idle_i)); // R2
    AST_FILL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we_o && unit_wstate_o == 2'd1) |->
        (unit_state_i[{unit_widx_o, 1'b0} +: 2] == 2'd0)); // R5
    AST_FILL_CHARGES: assert property (@(posedge clk) disable iff (!rst_n)
        unit_we_o |-> (tok_dec_o && tok_dec_idx_o == unit_wkern_o)); // R5
    AST_TAKE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        (unit_we_o && unit_wstate_o == 2'd2) |->
        (unit_state_i[{unit_widx_o, 1'b0} +: 2] == 2'd1 &&
         unit_owner_i[unit_widx_o*KW +: KW] == tok_inc_idx_o)); // R6
    AST_TAKE_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
        tok_inc_o |-> (tok_dec_o && unit_we_o && tok_inc_idx_o != tok_dec_idx_o)); // R6
    AST_STATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        unit_we_o |-> (unit_wstate_o == 2'd1 || unit_wstate_o == 2'd2)); // R5
endmodule

bind token_partitioner tokpart_chk #(
    .NUM_UNITS(NUM_UNITS), .NUM_KERN(NUM_KERN), .TOK_W(TOK_W)
) u_chk (.*);

// File: tb/tb_token_partitioner.sv
`timescale 1ns/1ps
module tb_token_partitioner;
    localparam int N  = 8;
    localparam int K  = 4;
    localparam int TW = $clog2(N) + 2;
    localparam int UW = $clog2(N);
    localparam int KW = $clog2(K);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_insert = 1'b0, ev_idle = 1'b0;
    logic [2*N-1:0]  unit_state;
    logic [KW*N-1:0] unit_owner;
    logic [K-1:0]    kern_active, kern_work;
    logic [TW*K-1:0] kern_tok;
    logic busy_o, unit_we_o, tok_inc_o, tok_dec_o;
    logic [UW-1:0] unit_widx_o;
    logic [1:0] unit_wstate_o;
    logic [KW-1:0] unit_wkern_o, tok_inc_idx_o, tok_dec_idx_o;

    int st [N], own [N], nxt [N];
    int tok [K], act [K], work [K];
    int m_st [N], m_own [N], m_nxt [N], m_tok [K];
    int errors = 0, checks = 0, writes_seen = 0;

    always #10 clk = ~clk;

    always_comb begin
        for (int u = 0; u < N; u++) begin
            unit_state[2*u +: 2]   = st[u][1:0];
            unit_owner[KW*u +: KW] = own[u][KW-1:0];
        end
        for (int k = 0; k < K; k++) begin
            kern_active[k]       = act[k][0];
            kern_work[k]         = work[k][0];
            kern_tok[TW*k +: TW] = tok[k][TW-1:0];
        end
    end

    token_partitioner #(.NUM_UNITS(N), .NUM_KERN(K)) dut (
        .clk(clk), .rst_n(rst_n), .ev_insert_i(ev_insert), .ev_idle_i(ev_idle),
        .unit_state_i(unit_state), .unit_owner_i(unit_owner),
        .kern_active_i(kern_active), .kern_work_i(kern_work), .kern_tok_i(kern_tok),
        .busy_o(busy_o), .unit_we_o(unit_we_o), .unit_widx_o(unit_widx_o),
        .unit_wstate_o(unit_wstate_o), .unit_wkern_o(unit_wkern_o),
        .tok_inc_o(tok_inc_o), .tok_inc_idx_o(tok_inc_idx_o),
        .tok_dec_o(tok_dec_o), .tok_dec_idx_o(tok_dec_idx_o)
    );

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual !== expected) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    // One clock: capture the write outputs, let the edge pass, apply them to the tables
    task automatic tick();
        bit we = unit_we_o;
        int wi = int'(unit_widx_o), ws = int'(unit_wstate_o), wk = int'(unit_wkern_o);
        bit ti = tok_inc_o, td = tok_dec_o;
        int tii = int'(tok_inc_idx_o), tdi = int'(tok_dec_idx_o);
        @(posedge clk);
        #1;
        if (we) begin
            writes_seen++;
            st[wi] = ws;
            if (ws == 1) own[wi] = wk;
            else         nxt[wi] = wk;
        end
        if (ti) tok[tii] = tok[tii] + 1;
        if (td) tok[tdi] = tok[tdi] - 1;
        @(negedge clk);
    endtask

    // Reference: apply the requirement rules pass by pass on copies of the tables
    function automatic int ref_run();
        int moves = 0;
        for (int u = 0; u < N; u++) begin m_st[u] = st[u]; m_own[u] = own[u]; m_nxt[u] = nxt[u]; end
        for (int k = 0; k < K; k++) m_tok[k] = tok[k];
        for (int p = 0; p < 100; p++) begin
            int mx = -1, mn = -1, fr = -1, vic = -1;
            for (int k = 0; k < K; k++) begin
                if (act[k] != 0 && work[k] != 0 && (mx < 0 || m_tok[k] > m_tok[mx])) mx = k;
                if (act[k] != 0 && (mn < 0 || m_tok[k] < m_tok[mn])) mn = k;
            end
            for (int u = N-1; u >= 0; u--) if (m_st[u] == 0) fr = u;
            if (mn >= 0) for (int u = N-1; u >= 0; u--) if (m_st[u] == 1 && m_own[u] == mn) vic = u;
            if (mx >= 0 && fr >= 0) begin
                m_st[fr] = 1; m_own[fr] = mx; m_tok[mx]--; moves++;
            end else if (mx >= 0 && mn >= 0 && m_tok[mx] > m_tok[mn] + 1 && vic >= 0) begin
                m_st[vic] = 2; m_nxt[vic] = mx; m_tok[mn]++; m_tok[mx]--; moves++;
            end else break;
        end
        return moves;
    endfunction

    task automatic run_event(input bit use_idle, input int latch_at,
                             output int busy_cyc, output int first_we);
        if (use_idle) ev_idle = 1'b1; else ev_insert = 1'b1;
        tick();
        ev_idle = 1'b0; ev_insert = 1'b0;
        busy_cyc = 0; first_we = -1;
        while (busy_o && busy_cyc < 5000) begin
            busy_cyc++;
            if (unit_we_o && first_we < 0) first_we = busy_cyc;
            if (busy_cyc == latch_at) ev_idle = 1'b1;
            tick();
            ev_idle = 1'b0;
        end
    endtask

    task automatic do_case(input string name, input bit use_idle, input int latch_at,
                           output int moves, output int first_we);
        int bc;
        moves = ref_run();
        run_event(use_idle, latch_at, bc, first_we);
        if (latch_at > 0)
            check({name, " R8 busy length with remembered event"}, bc, (moves + 2) * (N + 1));
        else
            check({name, " R3 busy length"}, bc, (moves + 1) * (N + 1));
        for (int k = 0; k < K; k++) check({name, " R7 final token"}, tok[k], m_tok[k]);
        for (int u = 0; u < N; u++) begin
            check({name, " R7 final unit state"}, st[u], m_st[u]);
            check({name, " R7 final owner"}, own[u], m_own[u]);
            check({name, " R7 final next"}, nxt[u], m_nxt[u]);
        end
    endtask

    task automatic clear_tables();
        for (int u = 0; u < N; u++) begin st[u] = 0; own[u] = 0; nxt[u] = 0; end
        for (int k = 0; k < K; k++) begin tok[k] = 0; act[k] = 0; work[k] = 0; end
    endtask

    task automatic load_preempt_case();
        clear_tables();
        for (int u = 0; u < N; u++) begin st[u] = 1; own[u] = 0; end
        act[0] = 1; work[0] = 1; tok[0] = 0;
        act[1] = 1; work[1] = 1; tok[1] = 4;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int mv, fw, w0;
        int unsigned seed;
        seed = $urandom(32'd2024);
        clear_tables();
        repeat (3) @(negedge clk);
        check("R1 busy in reset", busy_o, 0);
        check("R1 write strobe in reset", unit_we_o, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 busy after reset", busy_o, 0);
        check("R1 inc/dec after reset", int'(tok_inc_o) + int'(tok_dec_o), 0);

        // No event: an unbalanced table must stay untouched
        load_preempt_case();
        w0 = writes_seen;
        repeat (20) tick();
        check("R2 no run without event", busy_o, 0);
        check("R2 no writes without event", writes_seen - w0, 0);

        // Two equal kernels fill free units; tie goes to the lower index
        clear_tables();
        act[0] = 1; work[0] = 1; tok[0] = 4;
        act[1] = 1; work[1] = 1; tok[1] = 4;
        do_case("fill", 1'b0, 0, mv, fw);
        check("R4 tie picks lower kernel", own[0], 0);
        check("R5 fill moves", mv, 8);
        check("R2 insert event starts run", fw, N + 1);

        // Debt: one kernel takes every free unit
        clear_tables();
        act[2] = 1; work[2] = 1; tok[2] = 2;
        do_case("debt", 1'b1, 0, mv, fw);
        check("R5 debt token count", tok[2], -6);
        check("R9 last unit owner", own[N-1], 2);

        // Preemption
        load_preempt_case();
        do_case("preempt", 1'b0, 0, mv, fw);
        check("R3 first write in decide cycle", fw, N + 1);
        check("R6 moves", mv, 2);
        check("R6 unit0 reserved", st[0], 2);
        check("R6 unit0 next", nxt[0], 1);
        check("R6 unit1 reserved", st[1], 2);
        check("R6 poorest incremented", tok[0], 2);

        // Balanced table: run with no write
        w0 = writes_seen;
        do_case("balanced", 1'b1, 0, mv, fw);
        check("R7 balanced no writes", writes_seen - w0, 0);

        // Poorest kernel owns no running unit: blocked
        clear_tables();
        for (int u = 0; u < N; u++) begin st[u] = 1; own[u] = 1; end
        act[0] = 1; work[0] = 0; tok[0] = -2;
        act[1] = 1; work[1] = 1; tok[1] = 5;
        w0 = writes_seen;
        do_case("blocked", 1'b0, 0, mv, fw);
        check("R7 blocked no writes", writes_seen - w0, 0);

        // Remembered events, early and on the final decision cycle
        load_preempt_case();
        do_case("latch-early", 1'b0, 3, mv, fw);
        load_preempt_case();
        do_case("latch-last", 1'b1, 3 * (N + 1), mv, fw);

        // Random tables, mostly occupied
        for (int t = 0; t < 40; t++) begin
            int lat;
            clear_tables();
            for (int k = 0; k < K; k++) begin
                act[k]  = ($urandom % 4 != 0) ? 1 : 0;
                work[k] = ($urandom % 3 != 0) ? 1 : 0;
                tok[k]  = int'($urandom % 11) - 4;
            end
            act[$urandom % K] = 1;
            for (int u = 0; u < N; u++) begin
                int r = int'($urandom % 8);
                st[u] = (r == 0) ? 0 : ((r < 6) ? 1 : 2);
                if (st[u] != 0) begin
                    int k = int'($urandom % K);
                    while (act[k] == 0) k = (k + 1) % K;
                    own[u] = k;
                end
            end
            lat = ($urandom % 4 == 0) ? int'($urandom % N) + 1 : 0;
            do_case("random", t[0], lat, mv, fw);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule